// File: doc/BRIEF.md
# Audio Record-Playback Sequencer

This block sequences a sampled-audio recorder. It works with an external converter that has active-low strobes, an external byte-wide static RAM and a DAC. The three share one data bus, and the DAC always shows whatever is on that bus. The block never touches the data itself. It only drives the converter's chip-select, read and start strobes, the RAM write and output enables, and the RAM address. It watches one input: the converter's active-low done flag.

A free-running sample tick cuts time into slots of `TICK_DIV` system cycles, and each slot serves one RAM address. The block alternates between two phases of `2**ADDR_W` slots each.

- **Record phase.** Each slot runs the same sequence:
  - pulse the converter's start strobe;
  - wait for the done flag, which is brought in through a synchronizer;
  - open the converter's output onto the bus;
  - pulse the RAM write enable while the data is steady;
  - release every strobe.

  If the done flag does not come within `DONE_TIMEOUT` cycles, that sample is skipped. The address still moves on, so the length of a phase does not change.
- **Playback phase.** The RAM output enable is held low, so the bus and the DAC carry the stored samples. The address steps once per tick, as in record.

Top module: `audio_rec_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `ram_addr` is 0, `ram_oe_n` is 1 (record phase), and `adc_cs_n`, `adc_rd_n`, `adc_wr_n` and `ram_we_n` are all 1.
- R2: The sample tick repeats every `TICK_DIV` cycles. The first tick opens the slot for address 0. Every later tick adds one to `ram_addr` (modulo `2**ADDR_W`), so address changes are exactly `TICK_DIV` cycles apart, and `ram_addr` changes at no other time.
- R3: When `ram_addr` wraps from `2**ADDR_W-1` to 0, the phase toggles. The block starts in record (`ram_oe_n`=1), and the phase changes at no other time.
- R4: `ram_oe_n` is 0 for the whole playback phase and 1 for the whole record phase. During playback the bus therefore carries, in each slot, the byte last written to that slot's address.
- R5: In every record slot, `adc_wr_n` goes low for exactly `WR_LOW_CYC` consecutive cycles, with `adc_cs_n` low at the same time. The rising edge of `adc_wr_n` starts the conversion.
- R6: During playback, `adc_wr_n`, `adc_rd_n`, `adc_cs_n` and `ram_we_n` stay at 1.
- R7: After the done flag falls, `adc_cs_n` and `adc_rd_n` go low for at least `RD_SETUP_CYC` cycles before `ram_we_n` falls. `ram_we_n` then stays low for `WE_LOW_CYC` cycles, entirely inside the read-low window, and `adc_rd_n` is still low in the cycle where `ram_we_n` rises. There is one write per completed conversion.
- R8: At every address change, all four active-low strobes are 1.
- R9: If the done flag stays high for `DONE_TIMEOUT` cycles after the start strobe rises, that slot has no read strobe and no RAM write, and the address still advances at the next tick.
- R10: `adc_wr_n` and `adc_rd_n` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_intr_n | input | 1 | Converter done flag, active low, asynchronous |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rd_n | output | 1 | Converter output enable / read strobe, active low |
| adc_wr_n | output | 1 | Converter start strobe, active low; rising edge starts a conversion |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low; low for the whole playback phase |
| ram_addr | output | ADDR_W | RAM address, one per sample slot |

## Verification
The hardest situation to reach from the ports is a conversion that never finishes in the middle of an otherwise normal record pass, followed by a check that the slot was skipped cleanly. The bench's converter model ignores the start strobe for one chosen address during the second record pass. That slot must then show no read strobe and no RAM write, and the address must still step on time. In the playback that follows, that address must return the byte from the first pass while its neighbours return the new data. Phase wrap is reached quickly because the bench shrinks the address width to three bits.

// File: rtl/audio_seq_pkg.sv
package audio_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_WAIT  = 3'd2,
    S_READ  = 3'd3,
    S_WRITE = 3'd4,
    S_REL   = 3'd5
  } rec_state_t;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sample_tick_gen.sv
module sample_tick_gen #(
  parameter int TICK_DIV = 2000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/addr_phase_ctr.sv
module addr_phase_ctr #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  output logic [ADDR_W-1:0] addr,
  output logic              play,
  output logic              oe_n
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      play  <= 1'b0;
      oe_n  <= 1'b1;
      armed <= 1'b0;
    end else if (tick) begin
      if (!armed) begin
        armed <= 1'b1;
      end else begin
        addr <= addr + 1'b1;
        if (addr == {ADDR_W{1'b1}}) begin
          play <= !play;
          oe_n <= play;
        end
      end
    end
  end
endmodule

// File: rtl/rec_strobe_fsm.sv
module rec_strobe_fsm
  import audio_seq_pkg::*;
#(
  parameter int WR_LOW_CYC   = 20,
  parameter int RD_SETUP_CYC = 20,
  parameter int WE_LOW_CYC   = 10,
  parameter int DONE_TIMEOUT = 1500,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic play,
  input  logic intr_n,
  output logic cs_n,
  output logic rd_n,
  output logic wr_n,
  output logic we_n
);
  localparam int CMAX = max4(WR_LOW_CYC, RD_SETUP_CYC, WE_LOW_CYC, DONE_TIMEOUT);
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] WR_LAST = CW'(WR_LOW_CYC - 1);
  localparam logic [CW-1:0] RD_LAST = CW'(RD_SETUP_CYC - 1);
  localparam logic [CW-1:0] WE_LAST = CW'(WE_LOW_CYC - 1);
  localparam logic [CW-1:0] TO_LAST = CW'(DONE_TIMEOUT - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   done;
  rec_state_t             st, nxt;
  logic [CW-1:0]          cnt, cnt_n;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= intr_n;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], intr_n};
      end
    end
  endgenerate

  assign done = !sync_q[SYNC_STAGES-1];

  always_comb begin
    nxt   = st;
    cnt_n = cnt + 1'b1;
    unique case (st)
      S_IDLE: begin
        cnt_n = '0;
        if (go && !play) nxt = S_START;
      end
      S_START: if (cnt == WR_LAST) begin nxt = S_WAIT; cnt_n = '0; end
      S_WAIT: begin
        if (done) begin
          nxt   = S_READ;
          cnt_n = '0;
        end else if (cnt == TO_LAST) begin
          nxt   = S_IDLE;
          cnt_n = '0;
        end
      end
      S_READ:  if (cnt == RD_LAST) begin nxt = S_WRITE; cnt_n = '0; end
      S_WRITE: if (cnt == WE_LAST) begin nxt = S_REL;   cnt_n = '0; end
      S_REL: begin
        nxt   = S_IDLE;
        cnt_n = '0;
      end
      default: begin
        nxt   = S_IDLE;
        cnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      cnt  <= '0;
      cs_n <= 1'b1;
      rd_n <= 1'b1;
      wr_n <= 1'b1;
      we_n <= 1'b1;
    end else begin
      st   <= nxt;
      cnt  <= cnt_n;
      wr_n <= !(nxt == S_START);
      cs_n <= !(nxt inside {S_START, S_READ, S_WRITE, S_REL});
      rd_n <= !(nxt inside {S_READ, S_WRITE, S_REL});
      we_n <= !(nxt == S_WRITE);
    end
  end
endmodule

// File: rtl/audio_rec_seq.sv
module audio_rec_seq #(
  parameter int ADDR_W       = 17,
  parameter int TICK_DIV     = 2000,
  parameter int WR_LOW_CYC   = 20,
  parameter int RD_SETUP_CYC = 20,
  parameter int WE_LOW_CYC   = 10,
  parameter int DONE_TIMEOUT = 1500,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adc_intr_n,
  output logic              adc_cs_n,
  output logic              adc_rd_n,
  output logic              adc_wr_n,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [ADDR_W-1:0] ram_addr
);
  logic tick, tick_d, play;

  sample_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  addr_phase_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk (clk),
    .rst (rst),
    .tick(tick),
    .addr(ram_addr),
    .play(play),
    .oe_n(ram_oe_n)
  );

  always_ff @(posedge clk) begin
    if (rst) tick_d <= 1'b0;
    else     tick_d <= tick;
  end

  rec_strobe_fsm #(
    .WR_LOW_CYC  (WR_LOW_CYC),
    .RD_SETUP_CYC(RD_SETUP_CYC),
    .WE_LOW_CYC  (WE_LOW_CYC),
    .DONE_TIMEOUT(DONE_TIMEOUT),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_fsm (
    .clk   (clk),
    .rst   (rst),
    .go    (tick_d),
    .play  (play),
    .intr_n(adc_intr_n),
    .cs_n  (adc_cs_n),
    .rd_n  (adc_rd_n),
    .wr_n  (adc_wr_n),
    .we_n  (ram_we_n)
  );
endmodule

// File: rtl/audio_rec_seq_chk.sv
module audio_rec_seq_chk #(
  parameter int ADDR_W     = 17,
  parameter int WR_LOW_CYC = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              adc_cs_n,
  input logic              adc_rd_n,
  input logic              adc_wr_n,
  input logic              ram_we_n,
  input logic              ram_oe_n,
  input logic [ADDR_W-1:0] ram_addr
);
  logic [31:0] wr_lo_cnt;

  always_ff @(posedge clk) begin
    if (rst)            wr_lo_cnt <= '0;
    else if (!adc_wr_n) wr_lo_cnt <= wr_lo_cnt + 1;
    else                wr_lo_cnt <= '0;
  end

  p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (ram_addr != $past(ram_addr)) |-> (ram_addr == ADDR_W'($past(ram_addr) + 1'b1)));

  p_phase_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(ram_addr) == {ADDR_W{1'b1}} && ram_addr == '0) |-> (ram_oe_n != $past(ram_oe_n)));

  p_phase_only_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (ram_oe_n != $past(ram_oe_n)) |-> (ram_addr == '0 && $past(ram_addr) == {ADDR_W{1'b1}}));

  p_wr_width_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_wr_n) |-> (wr_lo_cnt == WR_LOW_CYC));

  p_wr_with_cs_r5: assert property (@(posedge clk) disable iff (rst)
    !adc_wr_n |-> !adc_cs_n);

  p_quiet_play_r6: assert property (@(posedge clk) disable iff (rst)
    !ram_oe_n |-> (adc_wr_n && adc_rd_n && adc_cs_n && ram_we_n));

  p_we_in_read_r7: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> (!adc_rd_n && !adc_cs_n));

  p_we_fall_after_rd_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_we_n) |-> !$past(adc_rd_n));

  p_we_rise_rd_held_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we_n) |-> !adc_rd_n);

  p_strobes_idle_step_r8: assert property (@(posedge clk) disable iff (rst)
    (ram_addr != $past(ram_addr)) |-> (adc_wr_n && adc_rd_n && adc_cs_n && ram_we_n));

  p_no_wr_rd_overlap_r10: assert property (@(posedge clk) disable iff (rst)
    !(!adc_wr_n && !adc_rd_n));
endmodule

bind audio_rec_seq audio_rec_seq_chk #(
  .ADDR_W    (ADDR_W),
  .WR_LOW_CYC(WR_LOW_CYC)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .adc_cs_n(adc_cs_n),
  .adc_rd_n(adc_rd_n),
  .adc_wr_n(adc_wr_n),
  .ram_we_n(ram_we_n),
  .ram_oe_n(ram_oe_n),
  .ram_addr(ram_addr)
);

// File: tb/audio_rec_seq_tb.sv
`timescale 1ns/1ps
module audio_rec_seq_tb;
  localparam int AW    = 3;
  localparam int TD    = 40;
  localparam int WRC   = 3;
  localparam int RSC   = 2;
  localparam int WEC   = 2;
  localparam int TO    = 12;
  localparam int NSLOT = 1 << AW;
  localparam logic [AW-1:0] MUTE_ADDR = AW'(5);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          adc_intr_n;
  logic          adc_cs_n, adc_rd_n, adc_wr_n, ram_we_n, ram_oe_n;
  logic [AW-1:0] ram_addr;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0] mem [NSLOT];
  logic [7:0] adc_val = 8'h00;
  logic [7:0] bus_val;
  int         rec_pass = 0;
  bit         mute = 1'b0;
  bit         mon_en = 1'b0;

  int wr_bad = 0, we_bad = 0, play_bad = 0, edge_bad = 0, step_bad = 0, wrap_bad = 0;
  int wr_pulses = 0, we_pulses = 0, rd_falls = 0;

  always #2.5 clk = ~clk;

  audio_rec_seq #(
    .ADDR_W(AW), .TICK_DIV(TD), .WR_LOW_CYC(WRC), .RD_SETUP_CYC(RSC),
    .WE_LOW_CYC(WEC), .DONE_TIMEOUT(TO), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst(rst), .adc_intr_n(adc_intr_n),
    .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .adc_wr_n(adc_wr_n),
    .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .ram_addr(ram_addr)
  );

  assign bus_val = !ram_oe_n ? mem[ram_addr] :
                   (!adc_cs_n && !adc_rd_n) ? adc_val : 8'hFF;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sample_of(input int pass, input logic [AW-1:0] a);
    return (pass == 0 ? 8'h50 : 8'hA0) ^ 8'(a);
  endfunction

  // converter model: start on rising strobe, done low 6 cycles later, cleared by read
  initial begin
    int  left;
    bit  pwr;
    left = 0;
    pwr  = 1'b1;
    adc_intr_n = 1'b1;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (!adc_rd_n && !adc_cs_n) adc_intr_n = 1'b1;
        if (left > 0) begin
          left--;
          if (left == 0) adc_intr_n = 1'b0;
        end
        if (adc_wr_n && !pwr && !(mute && ram_addr == MUTE_ADDR)) begin
          left       = 6;
          adc_val    = sample_of(rec_pass, ram_addr);
          adc_intr_n = 1'b1;
        end
        pwr = adc_wr_n;
      end
    end
  end

  // RAM model: latch bus on the rising write enable
  initial begin
    for (int i = 0; i < NSLOT; i++) mem[i] = 8'h00;
    forever begin
      @(posedge ram_we_n);
      if (!rst) mem[ram_addr] = bus_val;
    end
  end

  // port monitor, sampled at falling edges
  initial begin
    bit            pwr, pwe, prd, poe;
    logic [AW-1:0] paddr;
    int            wr_run, rd_run, since, nchg;
    pwr = 1; pwe = 1; prd = 1; poe = 1; paddr = '0;
    wr_run = 0; rd_run = 0; since = 0; nchg = 0;
    forever begin
      @(negedge clk);
      if (mon_en) begin
        since++;
        if (!adc_wr_n) begin
          wr_run++;
          if (adc_cs_n) wr_bad++;
          if (!adc_rd_n) wr_bad++;
        end else begin
          if (!pwr) begin
            wr_pulses++;
            if (wr_run != WRC) wr_bad++;
          end
          wr_run = 0;
        end
        if (!adc_rd_n) begin
          if (prd) rd_falls++;
          rd_run++;
        end else rd_run = 0;
        if (!ram_we_n) begin
          if (adc_rd_n || adc_cs_n) we_bad++;
          if (pwe && rd_run <= RSC) we_bad++;
        end else if (!pwe) begin
          we_pulses++;
          if (adc_rd_n) we_bad++;
        end
        if (!ram_oe_n && !(adc_wr_n && adc_rd_n && adc_cs_n && ram_we_n)) play_bad++;
        if (ram_addr != paddr) begin
          if (!(adc_wr_n && adc_rd_n && adc_cs_n && ram_we_n)) edge_bad++;
          if (ram_addr != AW'(paddr + 1'b1)) step_bad++;
          if (nchg > 0 && since != TD) step_bad++;
          if (paddr == '1 && ram_addr == '0 && ram_oe_n == poe) wrap_bad++;
          nchg++;
          since = 0;
        end
        if (ram_oe_n != poe && !(paddr == '1 && ram_addr == '0)) wrap_bad++;
        pwr = adc_wr_n; pwe = ram_we_n; prd = adc_rd_n; poe = ram_oe_n; paddr = ram_addr;
      end
    end
  end

  task automatic t_reset_state;
    repeat (3) @(negedge clk);
    chk(ram_addr == '0, "R1 addr in reset", 32'(ram_addr), 0);
    chk({adc_cs_n, adc_rd_n, adc_wr_n, ram_we_n} == 4'hF, "R1 strobes in reset",
        {adc_cs_n, adc_rd_n, adc_wr_n, ram_we_n}, 4'hF);
    rst = 1'b0;
    @(negedge clk);
    chk(ram_oe_n == 1'b1, "R1 record phase after reset", ram_oe_n, 1);
    chk({adc_cs_n, adc_rd_n, adc_wr_n, ram_we_n} == 4'hF, "R1 strobes after reset",
        {adc_cs_n, adc_rd_n, adc_wr_n, ram_we_n}, 4'hF);
    mon_en = 1'b1;
  endtask

  task automatic t_first_slot;
    repeat (TD + 20) @(negedge clk);
    chk(ram_addr == '0, "R2 first slot serves address 0", 32'(ram_addr), 0);
    chk(we_pulses == 1, "R2 first slot wrote once", we_pulses, 1);
  endtask

  task automatic t_record(input int pass, input int exp_we);
    chk(ram_oe_n == 1'b1, "R4 oe high in record", ram_oe_n, 1);
    while (ram_oe_n) @(negedge clk);
    chk(wr_pulses == NSLOT, "R5 one start per record slot", wr_pulses, NSLOT);
    chk(we_pulses == exp_we, "R7 writes per record pass", we_pulses, exp_we);
    chk(rd_falls == exp_we, "R9 reads only for finished conversions", rd_falls, exp_we);
    chk(wr_bad == 0, "R5 R10 start strobe shape", wr_bad, 0);
    chk(we_bad == 0, "R7 write inside read window", we_bad, 0);
    chk(ram_addr == '0, "R3 wrap enters playback at 0", 32'(ram_addr), 0);
    if (pass == 1) chk(mem[MUTE_ADDR] == sample_of(0, MUTE_ADDR), "R9 skipped slot keeps old byte",
                       mem[MUTE_ADDR], sample_of(0, MUTE_ADDR));
  endtask

  task automatic t_playback(input int pass);
    for (int s = 0; s < NSLOT; s++) begin
      logic [7:0] exp;
      while (ram_addr != AW'(s)) @(negedge clk);
      repeat (TD / 2) @(negedge clk);
      exp = (pass == 1 && AW'(s) == MUTE_ADDR) ? sample_of(0, AW'(s)) : sample_of(pass, AW'(s));
      chk(!ram_oe_n && bus_val == exp, "R4 playback bus carries stored byte", bus_val, exp);
    end
    while (!ram_oe_n) @(negedge clk);
    chk(play_bad == 0, "R6 no strobes in playback", play_bad, 0);
    wr_pulses = 0; we_pulses = 0; rd_falls = 0;
  endtask

  task automatic t_final;
    chk(edge_bad == 0, "R8 strobes idle at slot edges", edge_bad, 0);
    chk(step_bad == 0, "R2 step and spacing of address", step_bad, 0);
    chk(wrap_bad == 0, "R3 phase toggles only on wrap", wrap_bad, 0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset_state();
    t_first_slot();
    rec_pass = 0;
    t_record(0, NSLOT);
    t_playback(0);
    rec_pass = 1;
    mute = 1'b1;
    t_record(1, NSLOT - 1);
    mute = 1'b0;
    t_playback(1);
    t_final();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule